// File: doc/BRIEF.md
# Sub-Screen Sample Demux and Line Decimator

This block sits on the write side of a picture-in-picture engine. It receives a stream of 6-bit samples from a time-shared converter. In that stream luma and the two colour-difference signals share one channel in a repeating eight-slot pattern. The block sorts each sample into its component and counts its horizontal position within the line. It then shrinks the picture vertically by merging groups of three or four scan lines into one, with a choice of two filter weightings.

Once the last line of a merge group has arrived, each merged sample becomes one write request to a field memory. A request carries a component tag, an address and 6 bits of data. A freeze control stops all writes, so the stored picture stays as it is. A fill control replaces every written value with a constant colour, either blue or gray.

The horizontal sync strobe marks the end of each scan line. The vertical sync strobe starts a new field. The memory array, the converter and the readout path lie outside this block.

Top module: `pip_subwrite`

## Requirements
- R1: Samples are counted modulo 8 per valid strobe. Slots 0, 2, 4 and 6 are luma (tag 0), slot 1 is R-Y (tag 1) and slot 3 is B-Y (tag 2). Slots 5 and 7 never cause a write.
- R2: A luma write goes to address `mline*NY + pos`. A colour-difference write goes to `mline*NC + pos`. Here `mline` is the merged line index since the vertical strobe, and `pos` counts that component's samples in the line, starting from 0.
- R3: With `hsize_quad` low, a line stores up to NY luma and NC samples of each colour-difference signal. With it high, the limits are NY*3/4 and NC*3/4, rounded down. Samples past a limit are dropped.
- R4: With `vsize_quad` low, three lines merge into one; with it high, four do. Writes are issued only while the last line of a group arrives.
- R5: With `coef_sel` low, all merged lines have weight 1. The result is (sum + floor(D/2)) / D, with D = 3 or 4 lines.
- R6: With `coef_sel` high, the inner lines have weight 2 and the outer lines weight 1, giving 1-2-1 or 1-2-2-1. The divisor D is 4 or 6, rounded as in R5.
- R7: While `freeze` is high, no write strobe is issued.
- R8: While `fill_en` is high, the written data is a constant chosen by `fill_blue`. Gray is Y=16, R-Y=32, B-Y=32. Blue is Y=12, R-Y=26, B-Y=58.
- R9: The vertical strobe clears the slot count, the positions, the merge phase and the merged line index. The horizontal strobe clears the slot count and the positions, then advances the merge phase.
- R10: Merged lines with index MLINES or above produce no write.
- R11: While and after reset, with no input samples, no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one slot per strobe |
| smp_data | input | 6 | Digitized sample |
| hsync_stb | input | 1 | End-of-line strobe |
| vsync_stb | input | 1 | Start-of-field strobe |
| vsize_quad | input | 1 | 0: merge 3 lines, 1: merge 4 lines |
| hsize_quad | input | 1 | 0: full line limits, 1: three-quarter limits |
| coef_sel | input | 1 | 0: equal weights, 1: centre-weighted |
| freeze | input | 1 | Suppress all writes |
| fill_en | input | 1 | Force written data to a constant |
| fill_blue | input | 1 | Fill colour: 1 blue, 0 gray |
| wr_en | output | 1 | Write strobe |
| wr_comp | output | 2 | Component tag: 0 Y, 1 R-Y, 2 B-Y |
| wr_addr | output | ADDR_W | Field memory address, ADDR_W = clog2(MLINES*NY) |
| wr_data | output | 6 | Data to write |

## Verification
The assertions assume that the three mode bits change only while no merged sample is in flight. They also assume that the two sync strobes never arrive in the same cycle as a valid sample. The bench changes modes only in idle gaps before a vertical strobe, and it keeps strobes and samples in separate cycles. Before each vertical strobe it sends a few stray samples, so that a missed clear would shift slots and addresses. Line lengths are not multiples of eight, so the horizontal clear is exercised on every line.

// File: rtl/pip_wr_pkg.sv
package pip_wr_pkg;

    localparam int SMP_W  = 6;
    localparam int POS_W  = 8;
    localparam int LINE_W = 8;
    localparam int ACC_W  = 9;

    typedef enum logic [1:0] {
        CMP_Y    = 2'd0,
        CMP_R    = 2'd1,
        CMP_B    = 2'd2,
        CMP_NONE = 2'd3
    } comp_e;

    // sample tagged with its place in the picture
    typedef struct packed {
        logic              valid;
        comp_e             comp;
        logic [POS_W-1:0]  pos;
        logic [1:0]        phase;
        logic [LINE_W-1:0] mline;
        logic [SMP_W-1:0]  data;
    } tag_t;

    // one finished vertically merged sample
    typedef struct packed {
        logic              valid;
        comp_e             comp;
        logic [POS_W-1:0]  pos;
        logic [LINE_W-1:0] mline;
        logic [SMP_W-1:0]  data;
    } merged_t;

    function automatic comp_e slot_comp(input logic [2:0] slot);
        if (!slot[0])          return CMP_Y;
        else if (slot == 3'd1) return CMP_R;
        else if (slot == 3'd3) return CMP_B;
        else                   return CMP_NONE;
    endfunction

    function automatic logic [1:0] last_phase(input logic quad);
        return quad ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [1:0] line_weight(input logic coef, input logic quad,
                                               input logic [1:0] phase);
        return (coef && phase != 2'd0 && phase < last_phase(quad)) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [2:0] merge_div(input logic coef, input logic quad);
        if (coef) return quad ? 3'd6 : 3'd4;
        else      return quad ? 3'd4 : 3'd3;
    endfunction

    function automatic logic [SMP_W-1:0] round_div(input logic [ACC_W-1:0] acc,
                                                   input logic [2:0] d);
        int t;
        t = int'(acc) + int'(d >> 1);
        return SMP_W'(t / int'(d));
    endfunction

    function automatic logic [SMP_W-1:0] fill_value(input comp_e c, input logic blue);
        case (c)
            CMP_Y:   return blue ? 6'd12 : 6'd16;
            CMP_R:   return blue ? 6'd26 : 6'd32;
            default: return blue ? 6'd58 : 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/pip_slot_tracker.sv
module pip_slot_tracker
    import pip_wr_pkg::*;
#(
    parameter int NY     = 192,
    parameter int NC     = 48,
    parameter int MLINES = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SMP_W-1:0]    smp_data,
    input  logic                hsync_stb,
    input  logic                vsync_stb,
    input  logic                vsize_quad,
    input  logic                hsize_quad,
    output tag_t                tag_o
);

    localparam int LIM_Y3 = NY;
    localparam int LIM_Y4 = (NY * 3) / 4;
    localparam int LIM_C3 = NC;
    localparam int LIM_C4 = (NC * 3) / 4;

    logic [2:0]        slot_q;
    logic [POS_W-1:0]  pos_y_q, pos_c_q;
    logic [1:0]        phase_q;
    logic [LINE_W-1:0] mline_q;
    tag_t              tag_q;

    comp_e             cur_comp;
    logic [POS_W-1:0]  pos_sel;
    logic              take;

    always_comb begin
        cur_comp = slot_comp(slot_q);
        pos_sel  = pos_y_q;
        take     = 1'b0;
        case (cur_comp)
            CMP_Y: take = pos_y_q < (hsize_quad ? POS_W'(LIM_Y4) : POS_W'(LIM_Y3));
            CMP_R, CMP_B: begin
                pos_sel = pos_c_q;
                take    = pos_c_q < (hsize_quad ? POS_W'(LIM_C4) : POS_W'(LIM_C3));
            end
            default: take = 1'b0;
        endcase
        take = take && smp_valid && (mline_q < LINE_W'(MLINES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            pos_y_q <= '0;
            pos_c_q <= '0;
            phase_q <= '0;
            mline_q <= '0;
            tag_q   <= '0;
        end else begin
            tag_q.valid <= 1'b0;
            if (vsync_stb) begin
                slot_q  <= '0;
                pos_y_q <= '0;
                pos_c_q <= '0;
                phase_q <= '0;
                mline_q <= '0;
            end else if (hsync_stb) begin
                slot_q  <= '0;
                pos_y_q <= '0;
                pos_c_q <= '0;
                if (phase_q >= last_phase(vsize_quad)) begin
                    phase_q <= '0;
                    if (mline_q < LINE_W'(MLINES)) mline_q <= mline_q + 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end else if (smp_valid) begin
                slot_q <= slot_q + 1'b1;
                if (take) begin
                    tag_q <= '{1'b1, cur_comp, pos_sel, phase_q, mline_q, smp_data};
                    if (cur_comp == CMP_Y) pos_y_q <= pos_y_q + 1'b1;
                    if (cur_comp == CMP_B) pos_c_q <= pos_c_q + 1'b1;
                end
            end
        end
    end

    assign tag_o = tag_q;

    // R1: empty slots never produce a tagged sample
    a_r1_no_empty_slot: assert property (@(posedge clk) disable iff (rst)
        tag_q.valid |-> tag_q.comp != CMP_NONE);

    // R3: positions stay inside the per-line limits
    a_r3_pos_limit: assert property (@(posedge clk) disable iff (rst)
        tag_q.valid |-> (tag_q.comp == CMP_Y ? int'(tag_q.pos) < NY : int'(tag_q.pos) < NC));

    // R10: nothing is tagged past the last stored merged line
    a_r10_line_limit: assert property (@(posedge clk) disable iff (rst)
        tag_q.valid |-> int'(tag_q.mline) < MLINES);

    // R9: a field strobe never passes a sample through
    a_r9_vsync_quiet: assert property (@(posedge clk) disable iff (rst)
        vsync_stb |=> !tag_q.valid);

endmodule

// File: rtl/pip_line_merge.sv
module pip_line_merge
    import pip_wr_pkg::*;
#(
    parameter int NY = 192,
    parameter int NC = 48
) (
    input  logic    clk,
    input  logic    rst,
    input  tag_t    tag_i,
    input  logic    vsize_quad,
    input  logic    coef_sel,
    output merged_t mrg_o
);

    localparam int DEPTH = NY + 2 * NC;
    localparam int IDX_W = $clog2(DEPTH);

    logic [ACC_W-1:0] acc_q [DEPTH];
    merged_t          mrg_q;

    logic [IDX_W-1:0] idx;
    logic [ACC_W-1:0] prod, sum;
    logic             is_last;

    always_comb begin
        case (tag_i.comp)
            CMP_Y:   idx = IDX_W'(tag_i.pos);
            CMP_R:   idx = IDX_W'(NY) + IDX_W'(tag_i.pos);
            default: idx = IDX_W'(NY + NC) + IDX_W'(tag_i.pos);
        endcase
        prod    = ACC_W'(tag_i.data) * ACC_W'(line_weight(coef_sel, vsize_quad, tag_i.phase));
        sum     = (tag_i.phase == 2'd0) ? prod : acc_q[idx] + prod;
        is_last = tag_i.phase >= last_phase(vsize_quad);
    end

    always_ff @(posedge clk) begin
        if (tag_i.valid) acc_q[idx] <= sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mrg_q <= '0;
        end else begin
            mrg_q.valid <= 1'b0;
            if (tag_i.valid && is_last)
                mrg_q <= '{1'b1, tag_i.comp, tag_i.pos, tag_i.mline,
                           round_div(sum, merge_div(coef_sel, vsize_quad))};
        end
    end

    assign mrg_o = mrg_q;

    // R4: merged output only follows a sample of the last line in a group
    a_r4_emit_on_last: assert property (@(posedge clk) disable iff (rst)
        mrg_q.valid |-> $past(tag_i.valid) && ($past(tag_i.phase) >= last_phase($past(vsize_quad))));

endmodule

// File: rtl/pip_write_port.sv
module pip_write_port
    import pip_wr_pkg::*;
#(
    parameter int NY     = 192,
    parameter int NC     = 48,
    parameter int MLINES = 96,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  merged_t           mrg_i,
    input  logic              freeze,
    input  logic              fill_en,
    input  logic              fill_blue,
    output logic              wr_en,
    output comp_e             wr_comp,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SMP_W-1:0]  wr_data
);

    logic              wr_en_q;
    comp_e             comp_q;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [SMP_W-1:0]  data_q;

    always_comb begin
        addr_n = ADDR_W'(int'(mrg_i.mline) * ((mrg_i.comp == CMP_Y) ? NY : NC)
                         + int'(mrg_i.pos));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_q <= 1'b0;
            comp_q  <= CMP_Y;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            wr_en_q <= mrg_i.valid && !freeze;
            if (mrg_i.valid) begin
                comp_q <= mrg_i.comp;
                addr_q <= addr_n;
                data_q <= fill_en ? fill_value(mrg_i.comp, fill_blue) : mrg_i.data;
            end
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_comp = comp_q;
    assign wr_addr = addr_q;
    assign wr_data = data_q;

    // R7: frozen picture means no write in the following cycle
    a_r7_freeze_blocks: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !wr_en_q);

    // R8: fill mode writes only the selected constant
    a_r8_fill_const: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (!wr_en_q || data_q == fill_value(comp_q, $past(fill_blue))));

    // R2: addresses stay inside the component's region
    a_r2_addr_range: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> int'(addr_q) < ((comp_q == CMP_Y) ? MLINES * NY : MLINES * NC));

endmodule

// File: rtl/pip_subwrite.sv
module pip_subwrite
    import pip_wr_pkg::*;
#(
    parameter int NY     = 192,
    parameter int NC     = 48,
    parameter int MLINES = 96,
    parameter int ADDR_W = $clog2(MLINES * NY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [5:0]        smp_data,
    input  logic              hsync_stb,
    input  logic              vsync_stb,
    input  logic              vsize_quad,
    input  logic              hsize_quad,
    input  logic              coef_sel,
    input  logic              freeze,
    input  logic              fill_en,
    input  logic              fill_blue,
    output logic              wr_en,
    output logic [1:0]        wr_comp,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [5:0]        wr_data
);

    tag_t    tag;
    merged_t mrg;
    comp_e   comp_w;

    pip_slot_tracker #(.NY(NY), .NC(NC), .MLINES(MLINES)) tracker_i (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .hsync_stb  (hsync_stb),
        .vsync_stb  (vsync_stb),
        .vsize_quad (vsize_quad),
        .hsize_quad (hsize_quad),
        .tag_o      (tag)
    );

    pip_line_merge #(.NY(NY), .NC(NC)) merge_i (
        .clk        (clk),
        .rst        (rst),
        .tag_i      (tag),
        .vsize_quad (vsize_quad),
        .coef_sel   (coef_sel),
        .mrg_o      (mrg)
    );

    pip_write_port #(.NY(NY), .NC(NC), .MLINES(MLINES), .ADDR_W(ADDR_W)) wport_i (
        .clk       (clk),
        .rst       (rst),
        .mrg_i     (mrg),
        .freeze    (freeze),
        .fill_en   (fill_en),
        .fill_blue (fill_blue),
        .wr_en     (wr_en),
        .wr_comp   (comp_w),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign wr_comp = comp_w;

endmodule

// File: tb/pip_subwrite_tb_top.sv
module pip_subwrite_tb_top;

    localparam int TNY = 8;
    localparam int TNC = 2;
    localparam int TML = 2;
    localparam int TAW = $clog2(TML * TNY);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst = 1'b1;
    logic           smp_valid = 1'b0, hsync_stb = 1'b0, vsync_stb = 1'b0;
    logic [5:0]     smp_data = '0;
    logic           vsize_quad = 1'b0, hsize_quad = 1'b0, coef_sel = 1'b0;
    logic           freeze = 1'b0, fill_en = 1'b0, fill_blue = 1'b0;
    logic           wr_en;
    logic [1:0]     wr_comp;
    logic [TAW-1:0] wr_addr;
    logic [5:0]     wr_data;

    pip_subwrite #(.NY(TNY), .NC(TNC), .MLINES(TML)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .hsync_stb(hsync_stb), .vsync_stb(vsync_stb), .vsize_quad(vsize_quad),
        .hsize_quad(hsize_quad), .coef_sel(coef_sel), .freeze(freeze),
        .fill_en(fill_en), .fill_blue(fill_blue), .wr_en(wr_en),
        .wr_comp(wr_comp), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int got_c[$], got_a[$], got_d[$];
    int exp_c[$], exp_a[$], exp_d[$];

    always @(negedge clk) begin
        if (wr_en === 1'b1) begin
            got_c.push_back(int'(wr_comp));
            got_a.push_back(int'(wr_addr));
            got_d.push_back(int'(wr_data));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sval(input int cfg, input int l, input int k);
        return (l * 11 + k * 5 + cfg * 7 + (l * k) % 13) % 64;
    endfunction

    function automatic int fillc(input int comp, input bit blue);
        if (comp == 0) return blue ? 12 : 16;
        if (comp == 1) return blue ? 26 : 32;
        return blue ? 58 : 32;
    endfunction

    task automatic run_field(input int cfg, input bit vq, input bit hq, input bit cf,
                             input bit fz, input bit fl, input bit bl, input int len);
        int n, limy, limc, div, wsum;
        string dlab, clab;
        n    = vq ? 4 : 3;
        limy = hq ? (TNY * 3) / 4 : TNY;
        limc = hq ? (TNC * 3) / 4 : TNC;
        div  = cf ? (vq ? 6 : 4) : (vq ? 4 : 3);
        @(negedge clk);
        vsize_quad = vq; hsize_quad = hq; coef_sel = cf;
        freeze = fz; fill_en = fl; fill_blue = bl;
        // stray samples before the field strobe (R9)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = 6'(40 + k);
        end
        @(negedge clk); smp_valid = 1'b0; vsync_stb = 1'b1;
        @(negedge clk); vsync_stb = 1'b0;
        repeat (4) @(negedge clk);
        got_c.delete(); got_a.delete(); got_d.delete();
        // 3n lines: merged line 2 lies beyond TML (R10)
        for (int l = 0; l < 3 * n; l++) begin
            for (int k = 0; k < len; k++) begin
                @(negedge clk); smp_valid = 1'b1; smp_data = 6'(sval(cfg, l, k));
                if (k % 5 == 4) begin
                    @(negedge clk); smp_valid = 1'b0;
                end
            end
            @(negedge clk); smp_valid = 1'b0; hsync_stb = 1'b1;
            @(negedge clk); hsync_stb = 1'b0;
        end
        repeat (6) @(negedge clk);
        exp_c.delete(); exp_a.delete(); exp_d.delete();
        for (int m = 0; m < TML; m++) begin
            for (int k = 0; k < len; k++) begin
                int slot, comp, p;
                slot = k % 8;
                if (slot == 5 || slot == 7) continue;
                if (slot % 2 == 0) begin
                    comp = 0; p = (k / 8) * 4 + slot / 2;
                    if (p >= limy) continue;
                end else begin
                    comp = (slot == 1) ? 1 : 2; p = k / 8;
                    if (p >= limc) continue;
                end
                wsum = 0;
                for (int ph = 0; ph < n; ph++)
                    wsum += ((cf && ph != 0 && ph != n - 1) ? 2 : 1) * sval(cfg, m * n + ph, k);
                if (!fz) begin
                    exp_c.push_back(comp);
                    exp_a.push_back(m * ((comp == 0) ? TNY : TNC) + p);
                    exp_d.push_back(fl ? fillc(comp, bl) : (wsum + div / 2) / div);
                end
            end
        end
        clab = fz ? "R7" : (hq ? "R3/R10" : "R4/R10");
        chk(got_c.size() == exp_c.size(), clab, got_c.size(), exp_c.size());
        dlab = fl ? "R8" : (cf ? "R6" : "R5");
        for (int i = 0; i < exp_c.size() && i < got_c.size(); i++) begin
            chk(got_c[i] == exp_c[i], "R1", got_c[i], exp_c[i]);
            chk(got_a[i] == exp_a[i], "R2/R9", got_a[i], exp_a[i]);
            chk(got_d[i] == exp_d[i], dlab, got_d[i], exp_d[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R11", int'(wr_en), 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(wr_en == 1'b0, "R11", int'(wr_en), 0);
        end
        for (int c = 0; c < 8; c++) begin
            bit [2:0] c3;
            c3 = 3'(c);
            run_field(c, c3[0], c3[1], c3[2], 1'b0, 1'b0, 1'b0, (c < 4) ? 21 : 30);
        end
        run_field(8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 21);   // R7
        run_field(9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 21);   // R8 gray
        run_field(10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 13);  // R8 blue
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule